// File: doc/BRIEF.md
# Configuration Status Register with Sticky Error Flags

This block holds the 16-bit status half of the second configuration dword (byte offset 04h, dword index 1) of a bus agent. The bus interface logic feeds it single-cycle event pulses: parity errors, system errors, master and target aborts, and the data-phase parity error. It also feeds it two enable bits that the command register drives. Each error event latches into a flag that stays set until configuration software clears it. A flag clears when software writes a 1 to its bit position.

The register also carries fixed fields that never change:

- a capability-list indicator;
- a two-bit decode-timing code meaning "medium";
- zeros in every other unused position.

Configuration writes arrive as 32-bit dwords with byte enables. The status half sits in byte lanes 2 and 3. Reads use the same dword address and byte enables. They return the status value in the upper half of the dword and zero in every masked or unrelated byte.

Reset is asynchronous and active low. The reset input is expected to be de-asserted synchronously to `clk` by the reset tree outside this block.

Top module: `cfg_status_reg`

## Requirements
- R1: While reset is asserted and right after it, the status value reads 16'h0210.
- R2: Bits 10:9 always read 2'b01, bit 4 always reads 1, and bits 7:5, 3:0 and bit 9's neighbour bits outside the error set always read 0. Writing any value to them changes nothing.
- R3: Bit 15 becomes 1 on the clock after `ev_parity_err` pulses.
- R4: Bit 14 becomes 1 after `ev_sys_err` pulses only when `cmd_serr_en` is 1 in that same cycle. Otherwise it stays unchanged.
- R5: Bit 13 becomes 1 after `ev_master_abort` pulses, and bit 12 becomes 1 after `ev_target_abort_rcvd` pulses.
- R6: Bit 11 becomes 1 after `ev_target_abort_sig` pulses.
- R7: Bit 8 becomes 1 only when `perr_seen`, `is_bus_master` and `cmd_perr_resp` are all 1 in the same cycle. If any one of them is 0, bit 8 stays unchanged.
- R8: An error flag (bits 15:11 and 8) clears on the clock after a write that carries a 1 at its position. A 0 at its position leaves it unchanged.
- R9: If a set event and a write-1 clear reach the same flag in the same cycle, the flag ends at 1.
- R10: A write changes the status only when `cfg_addr` equals dword index 1. Status bits 15:8 take their clear mask from `cfg_wdata[31:24]` under `cfg_be[3]`. Status bits 7:0 map to `cfg_wdata[23:16]` under `cfg_be[2]`. A write with the enable for a lane at 0 has no effect on that lane.
- R11: `cfg_rdata` equals {status & {{8{cfg_be[3]}},{8{cfg_be[2]}}}, 16'h0000} when `cfg_addr` is 1, and 32'h0 for any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_parity_err | input | 1 | Pulse: address or data parity error detected |
| ev_sys_err | input | 1 | Pulse: this agent drives a system error |
| ev_master_abort | input | 1 | Pulse: own master cycle ended by master abort |
| ev_target_abort_rcvd | input | 1 | Pulse: own master cycle ended by target abort |
| ev_target_abort_sig | input | 1 | Pulse: this agent as target ended a cycle with target abort |
| perr_seen | input | 1 | Data parity error line observed asserted by any agent |
| is_bus_master | input | 1 | This agent owns the current data phase as master |
| cmd_perr_resp | input | 1 | Command register parity-response enable |
| cmd_serr_en | input | 1 | Command register system-error enable |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration dword index |
| cfg_be | input | 4 | Byte enables, active high |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr` / `cfg_be` |

## Verification
The embedded assertions watch every cycle for the following:

- a set event always leaving its flag high;
- a flag holding its value when neither a set nor a clear reaches it;
- a clear without a set leaving it low;
- the system-error and data-parity flags never rising while their qualifying conditions are absent;
- reads of other addresses returning zero;
- the fixed low byte.

Only the scenarios show the rest:

- the exact 16'h0210 reset value;
- each event reaching the correct bit position;
- the byte-lane routing of clears;
- a write-0 having no effect;
- the read masking.

// File: rtl/cfg_status_pkg.sv
package cfg_status_pkg;
  localparam int unsigned DW_W        = 32;
  localparam int unsigned STAT_W      = 16;
  localparam int unsigned ADDR_W      = 6;
  localparam int unsigned STAT_DW_IDX = 1;

  // Bit positions of the sticky error flags
  localparam int unsigned B_PAR_DET   = 15;
  localparam int unsigned B_SYS_SIG   = 14;
  localparam int unsigned B_MABT_RCV  = 13;
  localparam int unsigned B_TABT_RCV  = 12;
  localparam int unsigned B_TABT_SIG  = 11;
  localparam int unsigned B_DPAR_MST  = 8;

  localparam logic [STAT_W-1:0] ERR_MASK =
    (16'(1) << B_PAR_DET)  | (16'(1) << B_SYS_SIG) |
    (16'(1) << B_MABT_RCV) | (16'(1) << B_TABT_RCV) |
    (16'(1) << B_TABT_SIG) | (16'(1) << B_DPAR_MST);

  // Fixed read-only content: medium decode timing (01b at 10:9), capability list (bit 4)
  localparam logic [STAT_W-1:0] FIXED_VAL = 16'h0210;

  typedef struct packed {
    logic parity_err;
    logic sys_err;
    logic master_abort;
    logic tabort_rcvd;
    logic tabort_sig;
    logic perr_seen;
    logic is_master;
    logic perr_resp;
    logic serr_en;
  } stat_events_t;
endpackage

// File: rtl/stat_event_qual.sv
module stat_event_qual
  import cfg_status_pkg::*;
(
  input  stat_events_t          ev_i,
  output logic [STAT_W-1:0]     set_o
);
  always_comb begin
    set_o             = '0;
    set_o[B_PAR_DET]  = ev_i.parity_err;
    set_o[B_SYS_SIG]  = ev_i.sys_err & ev_i.serr_en;
    set_o[B_MABT_RCV] = ev_i.master_abort;
    set_o[B_TABT_RCV] = ev_i.tabort_rcvd;
    set_o[B_TABT_SIG] = ev_i.tabort_sig;
    set_o[B_DPAR_MST] = ev_i.perr_seen & ev_i.is_master & ev_i.perr_resp;
  end
endmodule

// File: rtl/stat_sticky_bit.sv
module stat_sticky_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_d;
  logic q_en;

  always_comb begin
    q_en = set_i | clr_i;
    q_d  = set_i | (q_o & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= 1'b0;
    else if (q_en)  q_o <= q_d;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o); // R9
  AST_CLEAR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !set_i) |=> $stable(q_o)); // R8
endmodule

// File: rtl/cfg_status_reg.sv
module cfg_status_reg
  import cfg_status_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_parity_err,
  input  logic              ev_sys_err,
  input  logic              ev_master_abort,
  input  logic              ev_target_abort_rcvd,
  input  logic              ev_target_abort_sig,
  input  logic              perr_seen,
  input  logic              is_bus_master,
  input  logic              cmd_perr_resp,
  input  logic              cmd_serr_en,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [3:0]        cfg_be,
  input  logic [DW_W-1:0]   cfg_wdata,
  output logic [DW_W-1:0]   cfg_rdata
);
  localparam int unsigned LANE_W = 8;
  localparam int unsigned LANES  = STAT_W / LANE_W;
  localparam int unsigned LANE0  = (DW_W - STAT_W) / LANE_W;

  stat_events_t       ev;
  logic [STAT_W-1:0]  set_vec;
  logic [STAT_W-1:0]  clr_vec;
  logic [STAT_W-1:0]  lane_mask;
  logic [STAT_W-1:0]  status;
  logic               hit;

  always_comb begin
    ev.parity_err   = ev_parity_err;
    ev.sys_err      = ev_sys_err;
    ev.master_abort = ev_master_abort;
    ev.tabort_rcvd  = ev_target_abort_rcvd;
    ev.tabort_sig   = ev_target_abort_sig;
    ev.perr_seen    = perr_seen;
    ev.is_master    = is_bus_master;
    ev.perr_resp    = cmd_perr_resp;
    ev.serr_en      = cmd_serr_en;
  end

  stat_event_qual u_qual (
    .ev_i  (ev),
    .set_o (set_vec)
  );

  assign hit = (cfg_addr == ADDR_W'(STAT_DW_IDX));

  // Byte-lane mask for the status half (dword lanes 2 and 3)
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_mask[l*LANE_W +: LANE_W] = {LANE_W{cfg_be[LANE0 + l]}};
  end

  always_comb begin
    clr_vec = '0;
    if (cfg_wr && hit)
      clr_vec = cfg_wdata[DW_W-1 -: STAT_W] & lane_mask;
  end

  for (genvar b = 0; b < STAT_W; b++) begin : g_bit
    if (ERR_MASK[b]) begin : g_err
      stat_sticky_bit u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_vec[b]),
        .clr_i (clr_vec[b]),
        .q_o   (status[b])
      );
    end else begin : g_fix
      assign status[b] = FIXED_VAL[b];
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (hit)
      cfg_rdata = {status & lane_mask, {(DW_W-STAT_W){1'b0}}};
  end

  AST_SERR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_serr_en && !status[B_SYS_SIG]) |=> !status[B_SYS_SIG]); // R4
  AST_DPAR_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    ((!perr_seen || !is_bus_master || !cmd_perr_resp) && !status[B_DPAR_MST])
      |=> !status[B_DPAR_MST]); // R7
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (cfg_rdata == '0)); // R11
  AST_FIXED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && cfg_be[2]) |-> (cfg_rdata[23:16] == 8'h10)); // R2
  AST_PARITY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ev_parity_err |=> status[B_PAR_DET]); // R3
endmodule

// File: tb/tb_cfg_status_reg.sv
`timescale 1ns/100ps
module tb_cfg_status_reg;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [8:0]  evv;   // [0]par [1]sys [2]mabt [3]tabt_r [4]tabt_s [5]perr [6]mst [7]perr_resp [8]serr_en
  logic        cfg_wr;
  logic [5:0]  cfg_addr;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;

  always #2.5 clk = ~clk;

  cfg_status_reg dut (
    .clk(clk), .rst_n(rst_n),
    .ev_parity_err(evv[0]), .ev_sys_err(evv[1]), .ev_master_abort(evv[2]),
    .ev_target_abort_rcvd(evv[3]), .ev_target_abort_sig(evv[4]),
    .perr_seen(evv[5]), .is_bus_master(evv[6]), .cmd_perr_resp(evv[7]),
    .cmd_serr_en(evv[8]),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
  );

  typedef struct { logic [31:0] data; string tag; } exp_t;
  exp_t        sb[$];
  int          n_chk = 0;
  int          n_err = 0;
  logic [15:0] model;
  bit          done = 0;

  function automatic logic [31:0] rd_model(logic [15:0] m, logic [5:0] a, logic [3:0] be);
    if (a != 6'd1) return 32'h0;
    return {m & {{8{be[3]}}, {8{be[2]}}}, 16'h0};
  endfunction

  // Driver: one clock of stimulus, expected read pushed after the edge
  task automatic cycle(input logic [8:0] e, input logic wr, input logic [5:0] a,
                       input logic [3:0] be, input logic [31:0] wd, input string tag);
    logic [15:0] setv, clrv;
    @(negedge clk);
    evv = e; cfg_wr = wr; cfg_addr = a; cfg_be = be; cfg_wdata = wd;
    setv = '0;
    setv[15] = e[0];
    setv[14] = e[1] & e[8];
    setv[13] = e[2];
    setv[12] = e[3];
    setv[11] = e[4];
    setv[8]  = e[5] & e[6] & e[7];
    clrv = (wr && a == 6'd1) ? (wd[31:16] & {{8{be[3]}}, {8{be[2]}}} & 16'hF900) : 16'h0;
    @(posedge clk);
    #1;
    model = setv | (model & ~clrv);
    sb.push_back('{rd_model(model, a, be), tag});
  endtask

  task automatic idle_read(input logic [3:0] be, input string tag);
    cycle(9'h0, 1'b0, 6'd1, be, 32'h0, tag);
  endtask

  // Monitor: pops expected items and compares them with the design's read data
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t it;
        it = sb.pop_front();
        n_chk++;
        if (cfg_rdata !== it.data) begin
          n_err++;
          $display("FAIL %s: got %h expected %h", it.tag, cfg_rdata, it.data);
        end
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; evv = '0; cfg_wr = 0; cfg_addr = 6'd1; cfg_be = 4'hF; cfg_wdata = '0;
    model = 16'h0210;
    #12;
    n_chk++;
    if (cfg_rdata !== 32'h0210_0000) begin
      n_err++; $display("FAIL R1: got %h expected %h", cfg_rdata, 32'h0210_0000);
    end
    @(negedge clk); rst_n = 1'b1;
    idle_read(4'hF, "R1 after reset");
    cycle(9'h0, 1, 6'd1, 4'hF, 32'hFFFF_FFFF, "R2 fixed fields ignore write");
    cycle(9'h0, 1, 6'd1, 4'hC, 32'h06EF_0000, "R2 fixed fields zero write");
    cycle(9'h001, 0, 6'd1, 4'hF, 0, "R3 parity event");
    cycle(9'h002, 0, 6'd1, 4'hF, 0, "R4 syserr without enable");
    cycle(9'h102, 0, 6'd1, 4'hF, 0, "R4 syserr with enable");
    cycle(9'h004, 0, 6'd1, 4'hF, 0, "R5 master abort");
    cycle(9'h008, 0, 6'd1, 4'hF, 0, "R5 target abort received");
    cycle(9'h010, 0, 6'd1, 4'hF, 0, "R6 target abort signaled");
    cycle(9'h060, 0, 6'd1, 4'hF, 0, "R7 no parity response");
    cycle(9'h0A0, 0, 6'd1, 4'hF, 0, "R7 not master");
    cycle(9'h0C0, 0, 6'd1, 4'hF, 0, "R7 no perr");
    cycle(9'h0E0, 0, 6'd1, 4'hF, 0, "R7 all three");
    cycle(9'h0, 1, 6'd1, 4'hF, 32'h0000_0000, "R8 write zero no effect");
    cycle(9'h0, 1, 6'd1, 4'h8, 32'h8000_0000, "R8 clear bit 15");
    cycle(9'h0, 1, 6'd1, 4'h4, 32'hFFFF_FFFF, "R10 lane 3 disabled");
    cycle(9'h0, 1, 6'd2, 4'hF, 32'hFFFF_FFFF, "R10 other address");
    idle_read(4'hF, "R10 status kept");
    cycle(9'h004, 1, 6'd1, 4'h8, 32'h2000_0000, "R9 set beats clear");
    cycle(9'h0, 1, 6'd1, 4'h8, 32'h0100_0000, "R8 clear bit 8");
    idle_read(4'h4, "R11 low lane only");
    idle_read(4'h8, "R11 high lane only");
    idle_read(4'h3, "R11 lanes 0-1 only");
    cycle(9'h0, 0, 6'd0, 4'hF, 0, "R11 other address read");
    cycle(9'h0, 1, 6'd1, 4'h8, 32'hFFFF_FFFF, "R8 clear all");
    cycle(9'h11F, 0, 6'd1, 4'hF, 0, "R3 several events together");
    idle_read(4'hF, "R8 flags sticky");
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule